// File: doc/BRIEF.md
# Flash Sector-Erase Command Controller

This block is the command front end for a NOR flash sector-erase flow. It watches bus write cycles, made of an address, a data byte and a one-cycle write strobe, for the six-write erase sequence. That sequence is two unlock writes, an erase setup byte, two more unlock writes, and a final sector-erase write whose address high bits name the sector.

The final write opens an acceptance window. Further sector-erase writes made while the window is open add sectors to an erase bitmap, and each one restarts the window. When the window expires, a cycle-counted erase runs for a fixed number of clocks. The erase can be suspended and later resumed without losing progress.

A ready/busy output shows whether the erase engine is occupied. Reads are made with a read strobe on the same address bus. A read that hits an erase in progress, or that hits a suspended sector, returns a status byte in place of array data. The flash array itself lives outside this block.

Top module: `sector_erase_ctrl`

## Requirements
- R1: The erase sequence is accepted only in this order, and only while idle:
  - 0xAA at address low bits 0x555;
  - 0x55 at 0x2AA;
  - 0x80 at 0x555;
  - 0xAA at 0x555;
  - 0x55 at 0x2AA;
  - 0x30 at any address, whose top SECT_W bits select the sector.

  After that last write, `ready` is low.
- R2: Any write that does not match the expected step returns the decoder to its first step. An incomplete sequence leaves `ready` high, and no erase starts.
- R3: The window closes WIN_CYC clocks after the most recent sector write. Erase then runs. Status bit 3 reads 0 while the window is open and 1 once it has closed.
- R4: A 0x30 write made while the window is open adds its sector to the erase set and restarts the window count.
- R5: The erase lasts ERASE_CYC clocks. The block then returns to idle with `ready` high and an empty erase set, and reads return no status.
- R6: During an active erase, every write other than 0xB0 is ignored. A 0x30 write adds no sector.
- R7: A 0xB0 write while the window is open closes the window at once and enters suspend on the next clock. In suspend, `ready` is high and status bit 3 is 1.
- R8: A 0xB0 write during an active erase enters suspend on the next clock, whatever its address.
- R9: In suspend, a read of a sector in the erase set returns status:
  - bit 7 is 0;
  - bit 6 is steady from read to read;
  - bit 2 flips on each such read.

  A read of a sector outside the set returns no status.
- R10: While the window is open or erase is active, every read returns status. Bit 7 is 0, and bit 6 flips between consecutive reads.
- R11: A 0x30 write in suspend resumes the erase from the clock count at which it stopped.
- R12: A synchronous reset aborts any erase and clears the erase set. After reset, `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also the hardware abort |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Bus address; top SECT_W bits give the sector |
| bus_wdata | input | 8 | Write data byte (command code) |
| ready | output | 1 | High when idle or suspended, low while the window is open or erase is active |
| rd_status_vld | output | 1 | One clock after a read: high if the read returned status |
| rd_status | output | 8 | Status byte: bit 7 poll, bit 6 toggle, bit 3 window closed, bit 2 set-sector toggle |

## Verification
The bench builds the block with WIN_CYC=16, ERASE_CYC=40, ADDR_W=14 and SECT_W=3. At those values, the window expiry, full erase completion and exact resume arithmetic can all be measured as whole cycle counts within a few dozen clocks. Eight sectors leave room to check, in a single run, that sectors added during the window are reported as members of the set, that sectors written during erase are not, and that sectors never written are not.

// File: rtl/sec_erase_pkg.sv
package sec_erase_pkg;

    typedef enum logic [1:0] {
        ES_IDLE,
        ES_WINDOW,
        ES_ERASE,
        ES_SUSPEND
    } erase_st_e;

    typedef enum logic [2:0] {
        CMD_OTHER,
        CMD_UNLK_A,
        CMD_UNLK_B,
        CMD_SETUP,
        CMD_SECT,
        CMD_SUSP
    } cmd_e;

    typedef struct packed {
        logic       poll;
        logic       tog;
        logic [1:0] rsv_hi;
        logic       closed;
        logic       set_tog;
        logic [1:0] rsv_lo;
    } status_t;

    localparam logic [10:0] UNLK_ADDR_A = 11'h555;
    localparam logic [10:0] UNLK_ADDR_B = 11'h2AA;
    localparam logic [2:0]  SEQ_LAST    = 3'd5;

    function automatic cmd_e classify(input logic [7:0] d);
        case (d)
            8'hAA:   return CMD_UNLK_A;
            8'h55:   return CMD_UNLK_B;
            8'h80:   return CMD_SETUP;
            8'h30:   return CMD_SECT;
            8'hB0:   return CMD_SUSP;
            default: return CMD_OTHER;
        endcase
    endfunction

    // Expected write for each step of the six-write erase sequence
    function automatic logic step_ok(input logic [2:0] step, input cmd_e c,
                                     input logic [10:0] a);
        case (step)
            3'd0, 3'd3: return (c == CMD_UNLK_A) && (a == UNLK_ADDR_A);
            3'd1, 3'd4: return (c == CMD_UNLK_B) && (a == UNLK_ADDR_B);
            3'd2:       return (c == CMD_SETUP)  && (a == UNLK_ADDR_A);
            3'd5:       return (c == CMD_SECT);
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sec_cmd_seq.sv
module sec_cmd_seq
    import sec_erase_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        armed,
    input  logic        we,
    input  cmd_e        cmd,
    input  logic [10:0] lo_addr,
    output logic        seq_done
);
    logic [2:0] step;
    logic       ok;

    always_comb ok = step_ok(step, cmd, lo_addr);

    assign seq_done = armed && we && ok && (step == SEQ_LAST);

    always_ff @(posedge clk) begin
        if (rst || !armed) begin
            step <= 3'd0;
        end else if (we) begin
            step <= (ok && step != SEQ_LAST) ? step + 3'd1 : 3'd0;
        end
    end

    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        armed && we && ok && step != SEQ_LAST |=> step == $past(step) + 3'd1) else $error("seq advance"); // R1
    AST_BAD_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        armed && we && !ok |=> step == 3'd0) else $error("bad write clear"); // R2

endmodule

// File: rtl/sec_erase_engine.sv
module sec_erase_engine
    import sec_erase_pkg::*;
#(
    parameter int N_SECT    = 8,
    parameter int WIN_CYC   = 2500,
    parameter int ERASE_CYC = 5000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  cmd_e                      cmd,
    input  logic [$clog2(N_SECT)-1:0] sect,
    input  logic                      seq_done,
    output erase_st_e                 state,
    output logic [N_SECT-1:0]         sect_set,
    output logic                      win_closed
);
    localparam int WW = $clog2(WIN_CYC + 1);
    localparam int EW = $clog2(ERASE_CYC + 1);

    logic [WW-1:0] win_cnt;
    logic [EW-1:0] er_cnt;
    logic          wr_sect, wr_susp;

    assign wr_sect = we && (cmd == CMD_SECT);
    assign wr_susp = we && (cmd == CMD_SUSP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ES_IDLE;
            sect_set   <= '0;
            win_cnt    <= '0;
            er_cnt     <= '0;
            win_closed <= 1'b0;
        end else begin
            case (state)
                ES_IDLE: if (seq_done) begin
                    state      <= ES_WINDOW;
                    sect_set   <= N_SECT'(1) << sect;
                    win_cnt    <= '0;
                    er_cnt     <= '0;
                    win_closed <= 1'b0;
                end
                ES_WINDOW: begin
                    if (wr_susp) begin
                        state      <= ES_SUSPEND;
                        win_closed <= 1'b1;
                    end else if (wr_sect) begin
                        sect_set[sect] <= 1'b1;
                        win_cnt        <= '0;
                    end else if (win_cnt == WW'(WIN_CYC - 1)) begin
                        state      <= ES_ERASE;
                        win_closed <= 1'b1;
                    end else begin
                        win_cnt <= win_cnt + 1'b1;
                    end
                end
                ES_ERASE: begin
                    if (wr_susp) begin
                        state <= ES_SUSPEND;
                    end else if (er_cnt == EW'(ERASE_CYC - 1)) begin
                        state      <= ES_IDLE;
                        sect_set   <= '0;
                        win_closed <= 1'b0;
                    end else begin
                        er_cnt <= er_cnt + 1'b1;
                    end
                end
                ES_SUSPEND: if (wr_sect) state <= ES_ERASE;
                default: state <= ES_IDLE;
            endcase
        end
    end

    AST_WIN_EXPIRES: assert property (@(posedge clk) disable iff (rst)
        state == ES_WINDOW && !wr_sect && !wr_susp && win_cnt == WW'(WIN_CYC - 1)
        |=> state == ES_ERASE && win_closed) else $error("window expiry"); // R3
    AST_WIN_ADD: assert property (@(posedge clk) disable iff (rst)
        state == ES_WINDOW && wr_sect && !wr_susp |=> state == ES_WINDOW && win_cnt == '0) else $error("window add"); // R4
    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        state == ES_IDLE |-> sect_set == '0) else $error("idle set"); // R5
    AST_ERASE_IGNORES: assert property (@(posedge clk) disable iff (rst)
        state == ES_ERASE && we && !wr_susp && er_cnt != EW'(ERASE_CYC - 1)
        |=> state == ES_ERASE && $stable(sect_set)) else $error("erase ignore"); // R6
    AST_SUSP_NEXT: assert property (@(posedge clk) disable iff (rst)
        state == ES_ERASE && wr_susp |=> state == ES_SUSPEND) else $error("suspend"); // R8
    AST_SUSP_HOLDS_CNT: assert property (@(posedge clk) disable iff (rst)
        state == ES_SUSPEND |=> $stable(er_cnt)) else $error("suspend count"); // R11

endmodule

// File: rtl/sec_status_read.sv
module sec_status_read
    import sec_erase_pkg::*;
#(
    parameter int N_SECT = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  erase_st_e                 state,
    input  logic [N_SECT-1:0]         sect_set,
    input  logic                      win_closed,
    input  logic                      rd_en,
    input  logic [$clog2(N_SECT)-1:0] rd_sect,
    output logic                      vld,
    output status_t                   stat
);
    logic busy, in_set, show;
    logic tog6, tog2;

    assign busy   = (state == ES_WINDOW) || (state == ES_ERASE);
    assign in_set = sect_set[rd_sect];
    assign show   = rd_en && (busy || (state == ES_SUSPEND && in_set));

    always_ff @(posedge clk) begin
        if (rst) begin
            vld  <= 1'b0;
            stat <= '0;
            tog6 <= 1'b0;
            tog2 <= 1'b0;
        end else begin
            vld <= show;
            if (show) begin
                stat <= '{poll: 1'b0, tog: tog6, rsv_hi: 2'b00, closed: win_closed,
                          set_tog: tog2, rsv_lo: 2'b00};
                if (busy)   tog6 <= ~tog6;
                if (in_set) tog2 <= ~tog2;
            end else begin
                stat <= '0;
            end
        end
    end

    AST_VLD_NEEDS_OP: assert property (@(posedge clk) disable iff (rst)
        vld |-> $past(state) != ES_IDLE) else $error("status while idle"); // R5
    AST_SUSP_ONLY_SET: assert property (@(posedge clk) disable iff (rst)
        rd_en && state == ES_SUSPEND && !in_set |=> !vld) else $error("suspend outside set"); // R9

endmodule

// File: rtl/sector_erase_ctrl.sv
module sector_erase_ctrl
    import sec_erase_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int SECT_W    = 3,
    parameter int WIN_CYC   = 2500,
    parameter int ERASE_CYC = 5000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic              ready,
    output logic              rd_status_vld,
    output logic [7:0]        rd_status
);
    localparam int N_SECT = 1 << SECT_W;

    cmd_e              cmd;
    erase_st_e         state;
    logic [SECT_W-1:0] sect;
    logic [N_SECT-1:0] sect_set;
    logic              win_closed, seq_done;
    status_t           stat;
    logic              unused_addr;

    assign cmd         = classify(bus_wdata);
    assign sect        = bus_addr[ADDR_W-1 -: SECT_W];
    assign unused_addr = ^bus_addr;

    sec_cmd_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .armed    (state == ES_IDLE),
        .we       (bus_we),
        .cmd      (cmd),
        .lo_addr  (bus_addr[10:0]),
        .seq_done (seq_done)
    );

    sec_erase_engine #(
        .N_SECT    (N_SECT),
        .WIN_CYC   (WIN_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_engine (
        .clk        (clk),
        .rst        (rst),
        .we         (bus_we),
        .cmd        (cmd),
        .sect       (sect),
        .seq_done   (seq_done),
        .state      (state),
        .sect_set   (sect_set),
        .win_closed (win_closed)
    );

    sec_status_read #(
        .N_SECT (N_SECT)
    ) u_status (
        .clk        (clk),
        .rst        (rst),
        .state      (state),
        .sect_set   (sect_set),
        .win_closed (win_closed),
        .rd_en      (bus_re),
        .rd_sect    (sect),
        .vld        (rd_status_vld),
        .stat       (stat)
    );

    assign ready     = (state == ES_IDLE) || (state == ES_SUSPEND);
    assign rd_status = stat;

    AST_SEQ_BUSY: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> !ready) else $error("sequence busy"); // R1
    AST_WIN_SUSPEND: assert property (@(posedge clk) disable iff (rst)
        state == ES_WINDOW && bus_we && cmd == CMD_SUSP |=> ready && win_closed) else $error("window suspend"); // R7
    AST_POLL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_status_vld) |-> !rd_status[7]) else $error("poll bit"); // R10

endmodule

// File: tb/test_sector_erase_ctrl.sv
module test_sector_erase_ctrl;
    localparam int W = 16;
    localparam int E = 40;
    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0, bus_re = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic          ready, rd_status_vld;
    logic [7:0]    rd_status;

    int checks = 0, fails = 0;
    logic       got_vld;
    logic [7:0] got_st;

    always #10 clk = ~clk;

    sector_erase_ctrl #(.ADDR_W(AW), .SECT_W(3), .WIN_CYC(W), .ERASE_CYC(E)) i_sector_erase_ctrl (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .ready(ready), .rd_status_vld(rd_status_vld), .rd_status(rd_status)
    );

    function automatic logic [AW-1:0] sa(input int s);
        return {s[2:0], 11'h000};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        bus_re = 1'b1; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_re = 1'b0;
        got_vld = rd_status_vld; got_st = rd_status;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic do_reset();
        rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic seq(input int s);
        wr(14'h555, 8'hAA); wr(14'h2AA, 8'h55); wr(14'h555, 8'h80);
        wr(14'h555, 8'hAA); wr(14'h2AA, 8'h55); wr(sa(s), 8'h30);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready && n < 1000) begin @(posedge clk); @(negedge clk); n++; end
    endtask

    task automatic t_reset_state();
        chk("R12 ready after reset", ready, 1);
        rd(sa(2));
        chk("R12 no status after reset", got_vld, 0);
    endtask

    task automatic t_malformed();
        wr(14'h555, 8'hAA); wr(14'h2AA, 8'h55); wr(14'h555, 8'h90);
        wr(14'h555, 8'hAA); wr(14'h2AA, 8'h55); wr(sa(1), 8'h30);
        chk("R2 ready after broken sequence", ready, 1);
        rd(sa(1));
        chk("R2 no erase started", got_vld, 0);
    endtask

    task automatic t_timing();
        int n;
        seq(1);
        chk("R1 busy after sequence", ready, 0);
        wait_ready(n);
        chk("R3 R5 window plus erase cycles", n, W + E);
        rd(sa(1));
        chk("R5 no status after completion", got_vld, 0);
    endtask

    task automatic t_multi();
        int n;
        seq(3); idle(5);
        wr(sa(6), 8'h30);
        wait_ready(n);
        chk("R4 window restarts on added sector", n, W + E);
    endtask

    task automatic t_status();
        logic b6;
        logic b2;
        seq(2);
        rd(sa(2));
        chk("R10 status in window", got_vld, 1);
        chk("R10 poll bit low", got_st[7], 0);
        chk("R3 window open bit3", got_st[3], 0);
        b6 = got_st[6];
        rd(sa(2));
        chk("R10 bit6 toggles", got_st[6], !b6);
        idle(W);
        rd(sa(7));
        chk("R10 status for any sector while erasing", got_vld, 1);
        chk("R3 window closed bit3", got_st[3], 1);
        wr(sa(5), 8'h30);
        wr(14'h123, 8'hB0);
        chk("R8 ready in suspend", ready, 1);
        rd(sa(5));
        chk("R6 sector write during erase ignored", got_vld, 0);
        rd(sa(2));
        chk("R9 status for set sector", got_vld, 1);
        chk("R9 poll bit low", got_st[7], 0);
        b6 = got_st[6]; b2 = got_st[2];
        rd(sa(2));
        chk("R9 bit6 steady", got_st[6], b6);
        chk("R9 bit2 toggles", got_st[2], !b2);
        rd(sa(0));
        chk("R9 no status outside set", got_vld, 0);
        do_reset();
        chk("R12 ready after abort", ready, 1);
        rd(sa(2));
        chk("R12 set cleared by abort", got_vld, 0);
    endtask

    task automatic t_susp_window();
        int n;
        seq(3); idle(3);
        wr(sa(6), 8'h30); idle(2);
        wr(14'h000, 8'hB0);
        chk("R7 ready after window suspend", ready, 1);
        rd(sa(6));
        chk("R7 added sector in set", got_vld, 1);
        chk("R7 bit3 set after window suspend", got_st[3], 1);
        rd(sa(3));
        chk("R7 first sector in set", got_vld, 1);
        rd(sa(4));
        chk("R9 unlisted sector not in set", got_vld, 0);
        wr(sa(0), 8'h30);
        chk("R11 busy after resume", ready, 0);
        wait_ready(n);
        chk("R11 full erase after window suspend", n, E);
    endtask

    task automatic t_resume();
        int n;
        seq(0); idle(20);
        wr(14'h3FF, 8'hB0);
        chk("R8 suspended during erase", ready, 1);
        idle(7);
        wr(sa(0), 8'h30);
        wait_ready(n);
        chk("R11 erase resumes from stop point", n, E - (20 - W));
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_malformed();
        t_timing();
        t_multi();
        t_status();
        t_susp_window();
        t_resume();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog R5 actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule